// File: doc/BRIEF.md
# SPI Interrupt Event Controller

This block gathers the interrupt sources of an SPI peripheral into one interrupt request line. Single-cycle event pulses from the SPI core and edges seen on three raw pins are latched into a sticky status register. The pulses cover transmit FIFO empty, transfer complete, transmit phase done, receive overflow and transmit underflow. The three pins are a ready handshake line, MISO and chip select. A 16-bit enable register gates which of those sources may latch and which pending flags drive the interrupt.

The ready-edge source is chosen by a two-bit flow mode. One value selects the ready pin and another selects MISO. The other two values switch the source off. A polarity input picks whether the rising or the falling edge counts. Chip-select edges raise a flag only for a slave running in continuous mode. Software reaches both registers through a simple select/write/read port and clears flags by writing ones.

The block holds no state machine. Its behaviour is a set of per-bit latch, clear and mask rules plus a fixed synchronizer pipeline for the pins.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x0000, the status register reads 0x0000 and `irq` is low.
- R2: A write to the enable register (`reg_sel`=0) stores only bits 14:8. Bits 15 and 7:0 always read as zero.
- R3: With the matching enable set, a pulse sets a status bit on the next clock edge. The enable bits and status bits are: tx-empty (enable 14) sets status 2; transfer-done (enable 13) sets status 1; receive-overflow (enable 10) sets status 5; transmit-underflow (enable 9) sets status 4.
- R4: An event whose enable bit is clear leaves no status bit set.
- R5: The transmit-done pulse (enable bit 12) sets status bit 3 only while `rd_cmd_mode` is high.
- R6: Ready edges (enable bit 11) set status bit 15. The source is the ready pin when `flow_mode`=2'b10 and MISO when `flow_mode`=2'b11. With `flow_mode` 2'b00 or 2'b01 there is no source. With `rdy_rise_sel`=1 the rising edge is active, and with 0 the falling edge is active.
- R7: A rising or falling edge on `cs_pin` sets status bits 14 and 13 only when `master_mode`=0, `cont_mode`=1 and enable bit 8 is set. Otherwise it has no effect.
- R8: A pin change first shows in status on the third rising clock edge after it. A single level change is flagged only once.
- R9: Writing 1 to a status bit (`reg_sel`=1) clears it, and writing 0 leaves it. If a set and a clear hit the same bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly when some status bit is set and its enable bit is set. Clearing the enable bit drops `irq` but keeps the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_txempty | input | 1 | Transmit FIFO emptied pulse |
| ev_xfrdone | input | 1 | Transfer complete pulse |
| ev_txdone | input | 1 | Transmit phase done pulse (read-command mode) |
| ev_rxovr | input | 1 | Receive overflow pulse |
| ev_txundr | input | 1 | Transmit underflow pulse |
| rdy_pin | input | 1 | Raw ready handshake pin |
| miso_pin | input | 1 | Raw MISO pin |
| cs_pin | input | 1 | Raw chip-select pin |
| master_mode | input | 1 | 1 = master, 0 = slave |
| cont_mode | input | 1 | Continuous transfer mode |
| rd_cmd_mode | input | 1 | Read-command mode active |
| flow_mode | input | 2 | Ready-edge source select |
| rdy_rise_sel | input | 1 | 1 = rising ready edge, 0 = falling |
| reg_sel | input | 1 | 0 = enable register, 1 = status register |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
A core event pulse driven before a clock edge is visible in status and on `irq` right after that edge. A pin change is visible only after the third edge, so pin checks look after two edges to confirm nothing is set yet and after the third to confirm the flag. The bench drives inputs and samples on the falling clock edge, so every check falls in a known cycle. Register writes take effect at the next rising edge and are read back one half cycle later.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int REG_W = 16;

    // enable bit positions
    localparam int EN_TXEMPTY = 14;
    localparam int EN_XFRDONE = 13;
    localparam int EN_TXDONE  = 12;
    localparam int EN_RDY     = 11;
    localparam int EN_RXOVR   = 10;
    localparam int EN_TXUNDR  = 9;
    localparam int EN_CS      = 8;

    // status bit positions
    localparam int ST_RDY     = 15;
    localparam int ST_CS_A    = 14;
    localparam int ST_CS_B    = 13;
    localparam int ST_RXOVR   = 5;
    localparam int ST_TXUNDR  = 4;
    localparam int ST_TXDONE  = 3;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_XFRDONE = 1;

    localparam logic [REG_W-1:0] EN_MASK = 16'h7F00;
    localparam logic [REG_W-1:0] ST_MASK = 16'hE03E;

    typedef enum logic [1:0] {
        FLOW_NONE_A  = 2'b00,
        FLOW_NONE_B  = 2'b01,
        FLOW_RDY_PIN = 2'b10,
        FLOW_MISO    = 2'b11
    } flow_mode_e;

    // spread enable bits onto the status positions they gate
    function automatic logic [REG_W-1:0] en_to_st(input logic [REG_W-1:0] en);
        logic [REG_W-1:0] m;
        m             = '0;
        m[ST_RDY]     = en[EN_RDY];
        m[ST_CS_A]    = en[EN_CS];
        m[ST_CS_B]    = en[EN_CS];
        m[ST_RXOVR]   = en[EN_RXOVR];
        m[ST_TXUNDR]  = en[EN_TXUNDR];
        m[ST_TXDONE]  = en[EN_TXDONE];
        m[ST_TXEMPTY] = en[EN_TXEMPTY];
        m[ST_XFRDONE] = en[EN_XFRDONE];
        return m;
    endfunction
endpackage

// File: rtl/spi_irq_pin_sync.sv
module spi_irq_pin_sync #(
    parameter int NPINS  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    // warm-up so reset values of the chain never look like an edge
    logic [STAGES:0] warm_q;
    logic            warm_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= {warm_q[STAGES-1:0], 1'b1};
    end
    assign warm_ok = warm_q[STAGES];

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [STAGES:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], pin_in[g]};
        end
        assign rise[g] = warm_ok &  sh_q[STAGES-1] & ~sh_q[STAGES];
        assign fall[g] = warm_ok & ~sh_q[STAGES-1] &  sh_q[STAGES];

        // R8: one level change yields one edge indication
        p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
        p_single_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] |=> !fall[g]);
    end
endmodule

// File: rtl/spi_irq_rdy_src.sv
module spi_irq_rdy_src
    import spi_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] flow_mode,
    input  logic       rise_sel,
    input  logic       rdy_rise,
    input  logic       rdy_fall,
    input  logic       miso_rise,
    input  logic       miso_fall,
    output logic       rdy_evt
);
    flow_mode_e mode;
    assign mode = flow_mode_e'(flow_mode);

    always_comb begin
        unique case (mode)
            FLOW_RDY_PIN: rdy_evt = rise_sel ? rdy_rise  : rdy_fall;
            FLOW_MISO:    rdy_evt = rise_sel ? miso_rise : miso_fall;
            FLOW_NONE_A,
            FLOW_NONE_B:  rdy_evt = 1'b0;
            default:      rdy_evt = 1'b0;
        endcase
    end

    // R6: no ready source in the two disabled modes
    p_no_rdy_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_mode[1] |-> !rdy_evt);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
    parameter int                 W    = 16,
    parameter logic [W-1:0]       MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status
);
    logic [W-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= ((st_q & ~clr_vec) | set_vec) & MASK;
    end
    assign status = st_q;

    // R9: a cleared bit with no competing set is gone next cycle
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(clr_vec) & ~$past(set_vec)) == '0));
    // R9: set wins over clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(set_vec) & MASK) & ~st_q) == '0));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_txempty,
    input  logic             ev_xfrdone,
    input  logic             ev_txdone,
    input  logic             ev_rxovr,
    input  logic             ev_txundr,
    input  logic             rdy_pin,
    input  logic             miso_pin,
    input  logic             cs_pin,
    input  logic             master_mode,
    input  logic             cont_mode,
    input  logic             rd_cmd_mode,
    input  logic [1:0]       flow_mode,
    input  logic             rdy_rise_sel,
    input  logic             reg_sel,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    localparam int PIN_RDY  = 0;
    localparam int PIN_MISO = 1;
    localparam int PIN_CS   = 2;
    localparam int NPINS    = 3;

    logic [REG_W-1:0] en_q, en_map, raw_set, set_vec, clr_vec, status;
    logic [NPINS-1:0] pins, p_rise, p_fall;
    logic             rdy_evt, cs_evt;

    // enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     en_q <= '0;
        else if (reg_wr_en && !reg_sel) en_q <= reg_wdata & EN_MASK;
    end
    assign en_map = en_to_st(en_q);

    // pin edges
    assign pins = {cs_pin, miso_pin, rdy_pin};

    spi_irq_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .rise(p_rise), .fall(p_fall)
    );

    spi_irq_rdy_src u_rdy (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .rise_sel(rdy_rise_sel),
        .rdy_rise(p_rise[PIN_RDY]), .rdy_fall(p_fall[PIN_RDY]),
        .miso_rise(p_rise[PIN_MISO]), .miso_fall(p_fall[PIN_MISO]),
        .rdy_evt(rdy_evt)
    );

    assign cs_evt = (p_rise[PIN_CS] | p_fall[PIN_CS]) & ~master_mode & cont_mode;

    always_comb begin
        raw_set             = '0;
        raw_set[ST_RDY]     = rdy_evt;
        raw_set[ST_CS_A]    = cs_evt;
        raw_set[ST_CS_B]    = cs_evt;
        raw_set[ST_RXOVR]   = ev_rxovr;
        raw_set[ST_TXUNDR]  = ev_txundr;
        raw_set[ST_TXDONE]  = ev_txdone & rd_cmd_mode;
        raw_set[ST_TXEMPTY] = ev_txempty;
        raw_set[ST_XFRDONE] = ev_xfrdone;
    end
    assign set_vec = raw_set & en_map;
    assign clr_vec = (reg_wr_en && reg_sel) ? reg_wdata : '0;

    spi_irq_status #(.W(REG_W), .MASK(ST_MASK)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .status(status)
    );

    assign reg_rdata = reg_sel ? status : en_q;
    assign irq       = |(status & en_map);

    // R2: enable write lands masked
    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_sel) |=> (en_q == ($past(reg_wdata) & EN_MASK)));
    // R4: new status bits only appear where enabled
    p_masked_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(en_map)) == '0));
    // R5: transmit-done flag only from read-command mode
    p_txdone_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_TXDONE]) |-> $past(rd_cmd_mode));
    // R7: chip-select flags only as continuous slave
    p_cs_slave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_CS_A]) |-> ($past(cont_mode) && !$past(master_mode)));
    // R10: interrupt needs a pending flag
    p_irq_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

// File: tb/spi_irq_ctrl_tb.sv
module spi_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ev = '0; // 0 txempty,1 xfrdone,2 txdone,3 rxovr,4 txundr
    logic        rdy_pin = 1'b0, miso_pin = 1'b0, cs_pin = 1'b1;
    logic        master_mode = 1'b0, cont_mode = 1'b0, rd_cmd_mode = 1'b0;
    logic [1:0]  flow_mode = 2'b00;
    logic        rdy_rise_sel = 1'b1;
    logic        reg_sel = 1'b0, reg_wr_en = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    spi_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_txempty(ev[0]), .ev_xfrdone(ev[1]), .ev_txdone(ev[2]),
        .ev_rxovr(ev[3]), .ev_txundr(ev[4]),
        .rdy_pin(rdy_pin), .miso_pin(miso_pin), .cs_pin(cs_pin),
        .master_mode(master_mode), .cont_mode(cont_mode), .rd_cmd_mode(rd_cmd_mode),
        .flow_mode(flow_mode), .rdy_rise_sel(rdy_rise_sel),
        .reg_sel(reg_sel), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [15:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        ev[idx] = 1'b1;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic pin_wait3;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(1'b0, d); chk("R1 enable", d, 16'h0000);
        rd(1'b1, d); chk("R1 status", d, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_enable_rw;
        logic [15:0] d;
        wr(1'b0, 16'hFFFF); rd(1'b0, d); chk("R2 all ones", d, 16'h7F00);
        wr(1'b0, 16'h80FF); rd(1'b0, d); chk("R2 reserved only", d, 16'h0000);
    endtask

    task automatic t_events;
        logic [15:0] d;
        wr(1'b0, 16'h7F00);
        pulse(0); rd(1'b1, d); chk("R3 txempty", d, 16'h0004);
        chk("R10 irq set", {15'd0, irq}, 16'h0001);
        wr(1'b1, 16'h0004); rd(1'b1, d); chk("R9 clear", d, 16'h0000);
        chk("R10 irq clear", {15'd0, irq}, 16'h0000);
        pulse(1); rd(1'b1, d); chk("R3 xfrdone", d, 16'h0002);
        pulse(3); rd(1'b1, d); chk("R3 rxovr", d, 16'h0022);
        pulse(4); rd(1'b1, d); chk("R3 txundr", d, 16'h0032);
        wr(1'b1, 16'h0010); rd(1'b1, d); chk("R9 partial clear", d, 16'h0022);
        wr(1'b1, 16'hFFFF); rd(1'b1, d); chk("R9 clear all", d, 16'h0000);
    endtask

    task automatic t_masked;
        logic [15:0] d;
        wr(1'b0, 16'h0000);
        pulse(0); pulse(1); pulse(3); pulse(4);
        rd(1'b1, d); chk("R4 masked events", d, 16'h0000);
        chk("R4 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_txdone;
        logic [15:0] d;
        wr(1'b0, 16'h7F00);
        rd_cmd_mode = 1'b0;
        pulse(2); rd(1'b1, d); chk("R5 not read-cmd", d, 16'h0000);
        rd_cmd_mode = 1'b1;
        pulse(2); rd(1'b1, d); chk("R5 read-cmd", d, 16'h0008);
        rd_cmd_mode = 1'b0;
        wr(1'b1, 16'hFFFF);
    endtask

    task automatic t_ready;
        logic [15:0] d;
        wr(1'b0, 16'h7F00);
        flow_mode = 2'b00; rdy_rise_sel = 1'b1;
        @(negedge clk); rdy_pin = 1'b1; pin_wait3; repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R6 mode 00 no source", d, 16'h0000);
        flow_mode = 2'b01;
        @(negedge clk); rdy_pin = 1'b0; pin_wait3; repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R6 mode 01 no source", d, 16'h0000);
        flow_mode = 2'b10;
        @(negedge clk); rdy_pin = 1'b1; rdy_pin = 1'b1;
        @(negedge clk); rdy_pin = 1'b0; pin_wait3; repeat (2) @(negedge clk);
        wr(1'b1, 16'hFFFF);
        // rising active: drive rise, check timing
        @(negedge clk); rdy_pin = 1'b1;
        repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R8 not before third edge", d, 16'h0000);
        @(negedge clk);
        rd(1'b1, d); chk("R6 ready pin rise", d, 16'h8000);
        chk("R8 third edge", d, 16'h8000);
        repeat (4) @(negedge clk);
        wr(1'b1, 16'h8000);
        repeat (4) @(negedge clk);
        rd(1'b1, d); chk("R8 once per change", d, 16'h0000);
        // falling edge is inactive with rise select
        @(negedge clk); rdy_pin = 1'b0; pin_wait3; repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R6 inactive polarity", d, 16'h0000);
        // miso ignored in mode 10
        @(negedge clk); miso_pin = 1'b1; pin_wait3; repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R6 miso ignored in 10", d, 16'h0000);
        // mode 11, falling polarity on miso
        flow_mode = 2'b11; rdy_rise_sel = 1'b0;
        @(negedge clk); miso_pin = 1'b0; pin_wait3;
        rd(1'b1, d); chk("R6 miso fall", d, 16'h8000);
        wr(1'b1, 16'h8000);
        rdy_rise_sel = 1'b1;
        @(negedge clk); miso_pin = 1'b1; pin_wait3;
        rd(1'b1, d); chk("R6 miso rise", d, 16'h8000);
        wr(1'b1, 16'hFFFF);
        flow_mode = 2'b00;
    endtask

    task automatic t_cs;
        logic [15:0] d;
        wr(1'b0, 16'h7F00);
        master_mode = 1'b1; cont_mode = 1'b1;
        @(negedge clk); cs_pin = 1'b0; pin_wait3; repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R7 master ignored", d, 16'h0000);
        master_mode = 1'b0; cont_mode = 1'b0;
        @(negedge clk); cs_pin = 1'b1; pin_wait3; repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R7 not continuous", d, 16'h0000);
        cont_mode = 1'b1;
        @(negedge clk); cs_pin = 1'b0; pin_wait3;
        rd(1'b1, d); chk("R7 slave fall", d, 16'h6000);
        wr(1'b1, 16'h6000);
        @(negedge clk); cs_pin = 1'b1; pin_wait3;
        rd(1'b1, d); chk("R7 slave rise", d, 16'h6000);
        wr(1'b1, 16'hFFFF);
        wr(1'b0, 16'h7E00);
        @(negedge clk); cs_pin = 1'b0; pin_wait3; repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R7 enable off", d, 16'h0000);
        @(negedge clk); cs_pin = 1'b1; pin_wait3; repeat (2) @(negedge clk);
        cont_mode = 1'b0;
    endtask

    task automatic t_set_wins;
        logic [15:0] d;
        wr(1'b0, 16'h7F00);
        @(negedge clk);
        ev[0] = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0004; reg_wr_en = 1'b1;
        @(negedge clk);
        ev = '0; reg_wr_en = 1'b0; reg_wdata = '0;
        rd(1'b1, d); chk("R9 set wins", d, 16'h0004);
    endtask

    task automatic t_irq_mask;
        logic [15:0] d;
        chk("R10 irq pending", {15'd0, irq}, 16'h0001);
        wr(1'b0, 16'h3F00);
        chk("R10 irq masked", {15'd0, irq}, 16'h0000);
        rd(1'b1, d); chk("R10 status kept", d, 16'h0004);
        wr(1'b0, 16'h7F00);
        chk("R10 irq back", {15'd0, irq}, 16'h0001);
        wr(1'b1, 16'hFFFF);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_enable_rw();
        t_events();
        t_masked();
        t_txdone();
        t_ready();
        t_cs();
        t_set_wins();
        t_irq_mask();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule